// File: doc/BRIEF.md
# Receive Channel-Status Capture and Event Flags

This block sits behind a serial digital-audio receiver whose line decoding is done elsewhere. For each decoded subframe it gets a strobe, the channel side, preamble information and the channel-status bit. The channel-status bits of the left subframes are gathered into a 192-bit page. The page is exposed as six 32-bit words, filled from the least significant bit of the first word upwards. It wraps back to the start after the last bit. A block-start preamble realigns the fill point to the start of the page.

Alongside the page, the block keeps six sticky event flags: block complete, block-start seen, bad preamble, user unit valid, receive FIFO overrun and transmit FIFO underrun. It also registers four FIFO attention levels. Together these form a ten-bit status vector. Software clears the sticky flags by writing ones to a clear vector. Each status bit has its own interrupt enable, and the enabled bits are merged into one interrupt line.

Top module: `cs_rx_capture`

## Requirements
- R1: A valid left subframe with a good preamble stores its channel-status bit at the current page position p, which is bit p mod 32 of word p/32 of `cs_page` (word k at `cs_page[32k+31:32k]`). The position then advances by one.
- R2: Position 191 is followed by position 0. Status bit 0 (block complete) sets on the cycle after position 191 is written, and not before.
- R3: A valid left subframe marked as block start (`sf_pre_b`) with a good preamble is stored at position 0, and the following stored bit goes to position 1.
- R4: Right subframes, and subframes with `sf_pre_bad` high, store nothing and leave the position unchanged.
- R5: Status bit 2 sets when a valid subframe has a bad preamble. Status bit 1 sets when a valid subframe is marked as block start and has a good preamble.
- R6: Status bit 3 sets on `unit_valid`, bit 4 on `rx_ovr` (receive data FIFO overrun) and bit 5 on `tx_und` (transmit data FIFO underrun), one cycle after the pulse.
- R7: Status bits 0 to 5 are sticky. Each clears only in a cycle where the matching bit of `flag_clr` is 1. A set event in that same cycle keeps the flag at 1.
- R8: Status bits 6 to 9 follow `fifo_attn[0]` to `fifo_attn[3]` one cycle later and are not sticky.
- R9: With the default combinational variant, `irq` is 1 exactly when some status bit and the same bit of `irq_en` are both 1.
- R10: After reset, status, page, position and `irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sf_valid | input | 1 | One-cycle strobe: a decoded subframe is present |
| sf_left | input | 1 | Subframe belongs to the left channel |
| sf_pre_b | input | 1 | Subframe carried the block-start preamble |
| sf_pre_bad | input | 1 | Subframe preamble was invalid or missing |
| sf_cbit | input | 1 | Channel-status bit of the subframe |
| unit_valid | input | 1 | Pulse: a valid user information unit was received |
| rx_ovr | input | 1 | Pulse: receive data FIFO overrun |
| tx_und | input | 1 | Pulse: transmit data FIFO underrun |
| fifo_attn | input | 4 | FIFO attention levels (rx user, tx user, rx data, tx data) |
| flag_clr | input | 6 | Write-one-to-clear strobes for status bits 0..5 |
| irq_en | input | 10 | Interrupt enable per status bit |
| cs_page | output | 192 | Channel-status page, six 32-bit words |
| status | output | 10 | Sticky flags [5:0] and attention levels [9:6] |
| irq | output | 1 | Merged interrupt |

## Verification
The assertions assume that `sf_valid` is a single-cycle strobe and that block-start marks arrive only with left subframes. They also assume that event pulses and clear strobes are synchronous to `clk` and that a subframe marked bad has no defined block-start meaning. The stimulus respects all of this. Each subframe is driven for exactly one cycle and then dropped. Block-start marks are given only to left subframes. Right subframes with inverted channel-status bits are interleaved, so any wrong storage would change the page. Clear strobes are sometimes placed in the same cycle as a set event, to exercise the priority rule.

// File: rtl/cs_rx_pkg.sv
package cs_rx_pkg;
   // sticky flag positions inside the status vector
   localparam int unsigned IX_BLK    = 0;
   localparam int unsigned IX_BSTART = 1;
   localparam int unsigned IX_BADPRE = 2;
   localparam int unsigned IX_UNIT   = 3;
   localparam int unsigned IX_RXOVR  = 4;
   localparam int unsigned IX_TXUND  = 5;
   localparam int unsigned N_STICKY  = 6;
   localparam int unsigned N_ATTN    = 4;
   localparam int unsigned N_STAT    = N_STICKY + N_ATTN;
endpackage

// File: rtl/cs_page_asm.sv
module cs_page_asm #(
   parameter int unsigned FRAMES = 192,
   parameter int unsigned WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sf_valid,
   input  logic              sf_left,
   input  logic              sf_pre_b,
   input  logic              sf_pre_bad,
   input  logic              sf_cbit,
   output logic [FRAMES-1:0] page,
   output logic              blk_done
);
   localparam int unsigned N_WORDS = FRAMES / WORD_W;
   localparam int unsigned BIT_W   = $clog2(WORD_W);
   localparam int unsigned WIDX_W  = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
   localparam logic [BIT_W-1:0]  BIT_LAST  = BIT_W'(WORD_W - 1);
   localparam logic [WIDX_W-1:0] WORD_LAST = WIDX_W'(N_WORDS - 1);

   if (FRAMES % WORD_W != 0) begin : g_bad_frames
      $error("cs_page_asm: FRAMES must be a multiple of WORD_W");
   end
   if (WORD_W < 2) begin : g_bad_word
      $error("cs_page_asm: WORD_W must be at least 2");
   end

   logic [WIDX_W-1:0] word_idx;
   logic [BIT_W-1:0]  bit_idx;
   logic              wr_en;
   logic [WIDX_W-1:0] word_sel;
   logic [BIT_W-1:0]  bit_sel;

   assign wr_en    = sf_valid && sf_left && !sf_pre_bad;
   assign word_sel = sf_pre_b ? '0 : word_idx;
   assign bit_sel  = sf_pre_b ? '0 : bit_idx;
   assign blk_done = wr_en && !sf_pre_b && (word_idx == WORD_LAST) && (bit_idx == BIT_LAST);

   // fill position
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_idx <= '0;
         bit_idx  <= '0;
      end else if (wr_en) begin
         if (sf_pre_b) begin
            word_idx <= '0;
            bit_idx  <= BIT_W'(1);
         end else if (bit_idx == BIT_LAST) begin
            bit_idx  <= '0;
            word_idx <= (word_idx == WORD_LAST) ? '0 : word_idx + WIDX_W'(1);
         end else begin
            bit_idx  <= bit_idx + BIT_W'(1);
         end
      end
   end

   // one storage word per page slot
   for (genvar w = 0; w < N_WORDS; w++) begin : g_word
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q <= '0;
         end else if (wr_en && (word_sel == WIDX_W'(w))) begin
            word_q[bit_sel] <= sf_cbit;
         end
      end
      assign page[w*WORD_W +: WORD_W] = word_q;
   end

   assert_idx_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      word_idx <= WORD_LAST);
   assert_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      blk_done |=> (word_idx == '0 && bit_idx == '0));
   assert_b_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && sf_pre_b) |=> (word_idx == '0 && bit_idx == BIT_W'(1)));
   assert_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_valid && (!sf_left || sf_pre_bad)) |=> ($stable(page) && $stable(bit_idx) && $stable(word_idx)));
endmodule

// File: rtl/cs_evt_flags.sv
module cs_evt_flags #(
   parameter int unsigned N_STICKY = 6,
   parameter int unsigned N_ATTN   = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [N_STICKY-1:0]        set_vec,
   input  logic [N_STICKY-1:0]        clr_vec,
   input  logic [N_ATTN-1:0]          attn,
   output logic [N_STICKY+N_ATTN-1:0] status
);
   if (N_STICKY < 1) begin : g_bad_n
      $error("cs_evt_flags: N_STICKY must be at least 1");
   end

   for (genvar i = 0; i < N_STICKY; i++) begin : g_flag
      logic q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 1'b0;
         else        q <= (q && !clr_vec[i]) || set_vec[i];
      end
      assign status[i] = q;

      assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (q && !clr_vec[i]) |=> q);
      assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
         set_vec[i] |=> q);
      assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_vec[i] && !set_vec[i]) |=> !q);
   end

   logic [N_ATTN-1:0] attn_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) attn_q <= '0;
      else        attn_q <= attn;
   end
   assign status[N_STICKY +: N_ATTN] = attn_q;
endmodule

// File: rtl/cs_irq_combine.sv
module cs_irq_combine #(
   parameter int unsigned N       = 10,
   parameter bit          REG_OUT = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] status,
   input  logic [N-1:0] en,
   output logic         irq
);
   logic hit;
   assign hit = |(status & en);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= hit;
      end
      assign irq = irq_q;
   end else begin : g_comb
      assign irq = hit;
      assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (en == '0) |-> !irq);
      assert_irq_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
         (status == '0) |-> !irq);
   end
endmodule

// File: rtl/cs_rx_capture.sv
module cs_rx_capture
   import cs_rx_pkg::*;
#(
   parameter int unsigned FRAMES  = 192,
   parameter int unsigned WORD_W  = 32,
   parameter bit          REG_IRQ = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sf_valid,
   input  logic                sf_left,
   input  logic                sf_pre_b,
   input  logic                sf_pre_bad,
   input  logic                sf_cbit,
   input  logic                unit_valid,
   input  logic                rx_ovr,
   input  logic                tx_und,
   input  logic [N_ATTN-1:0]   fifo_attn,
   input  logic [N_STICKY-1:0] flag_clr,
   input  logic [N_STAT-1:0]   irq_en,
   output logic [FRAMES-1:0]   cs_page,
   output logic [N_STAT-1:0]   status,
   output logic                irq
);
   logic                blk_done;
   logic [N_STICKY-1:0] set_vec;

   cs_page_asm #(.FRAMES(FRAMES), .WORD_W(WORD_W)) u_page (
      .clk        (clk),
      .rst_n      (rst_n),
      .sf_valid   (sf_valid),
      .sf_left    (sf_left),
      .sf_pre_b   (sf_pre_b),
      .sf_pre_bad (sf_pre_bad),
      .sf_cbit    (sf_cbit),
      .page       (cs_page),
      .blk_done   (blk_done)
   );

   always_comb begin
      set_vec            = '0;
      set_vec[IX_BLK]    = blk_done;
      set_vec[IX_BSTART] = sf_valid && sf_pre_b && !sf_pre_bad;
      set_vec[IX_BADPRE] = sf_valid && sf_pre_bad;
      set_vec[IX_UNIT]   = unit_valid;
      set_vec[IX_RXOVR]  = rx_ovr;
      set_vec[IX_TXUND]  = tx_und;
   end

   cs_evt_flags #(.N_STICKY(N_STICKY), .N_ATTN(N_ATTN)) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (flag_clr),
      .attn    (fifo_attn),
      .status  (status)
   );

   cs_irq_combine #(.N(N_STAT), .REG_OUT(REG_IRQ)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (status),
      .en     (irq_en),
      .irq    (irq)
   );

   assert_bstart_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_valid && sf_pre_b && !sf_pre_bad) |=> status[IX_BSTART]);
   assert_badpre_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_valid && sf_pre_bad) |=> status[IX_BADPRE]);
   assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ovr |=> status[IX_RXOVR]);
endmodule

// File: tb/tb_cs_rx_capture.sv
module tb_cs_rx_capture;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         sf_valid = 0, sf_left = 0, sf_pre_b = 0, sf_pre_bad = 0, sf_cbit = 0;
   logic         unit_valid = 0, rx_ovr = 0, tx_und = 0;
   logic [3:0]   fifo_attn = '0;
   logic [5:0]   flag_clr = '0;
   logic [9:0]   irq_en = '0;
   logic [191:0] cs_page;
   logic [9:0]   status;
   logic         irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;
   logic [191:0] exp_page;
   int exp_pos;

   always #2 clk = ~clk;

   cs_rx_capture dut (
      .clk(clk), .rst_n(rst_n), .sf_valid(sf_valid), .sf_left(sf_left),
      .sf_pre_b(sf_pre_b), .sf_pre_bad(sf_pre_bad), .sf_cbit(sf_cbit),
      .unit_valid(unit_valid), .rx_ovr(rx_ovr), .tx_und(tx_und),
      .fifo_attn(fifo_attn), .flag_clr(flag_clr), .irq_en(irq_en),
      .cs_page(cs_page), .status(status), .irq(irq)
   );

   // fields: [27:20] valid,left,bstart,bad,cbit,unit,ovr,und  [19:16] attn  [15:10] clr  [9:0] expected status
   localparam logic [27:0] TBL [12] = '{
      {8'b11001000, 4'h0, 6'h00, 10'h000},
      {8'b11100000, 4'h0, 6'h00, 10'h002},
      {8'b11010000, 4'h0, 6'h00, 10'h006},
      {8'b00000100, 4'h0, 6'h00, 10'h00E},
      {8'b00000000, 4'h0, 6'h02, 10'h00C},
      {8'b00000011, 4'h0, 6'h00, 10'h03C},
      {8'b00000000, 4'h5, 6'h00, 10'h17C},
      {8'b00000000, 4'h0, 6'h3F, 10'h000},
      {8'b11100000, 4'h0, 6'h02, 10'h002},
      {8'b00000000, 4'hA, 6'h02, 10'h280},
      {8'b10000000, 4'h0, 6'h00, 10'h000},
      {8'b00000100, 4'h0, 6'h08, 10'h008}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic pat(input int i);
      return logic'(((i * 7) % 5) < 2) ^ logic'((i >> 3) & 1);
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_page = '0;
      exp_pos = 0;
   endtask

   // one subframe for one cycle; model follows R1-style rules
   task automatic send_sf(input logic left, input logic b, input logic bad, input logic c);
      sf_valid = 1; sf_left = left; sf_pre_b = b; sf_pre_bad = bad; sf_cbit = c;
      if (left && !bad) begin
         if (b) exp_pos = 0;
         exp_page[exp_pos] = c;
         exp_pos = (exp_pos == 191) ? 0 : exp_pos + 1;
      end
      @(negedge clk);
      sf_valid = 0; sf_left = 0; sf_pre_b = 0; sf_pre_bad = 0; sf_cbit = 0;
   endtask

   task automatic chk_page(input string req);
      for (int w = 0; w < 6; w++) chk(req, cs_page[w*32 +: 32], exp_page[w*32 +: 32]);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      do_reset();
      // R10 reset state
      chk("R10 status", 32'(status), 32'h0);
      chk("R10 irq", 32'(irq), 32'h0);
      chk_page("R10 page");

      // table walk: flags, clears, attention, interrupt with all enables
      irq_en = '1;
      for (int k = 0; k < 12; k++) begin
         sf_valid = TBL[k][27]; sf_left = TBL[k][26]; sf_pre_b = TBL[k][25];
         sf_pre_bad = TBL[k][24]; sf_cbit = TBL[k][23]; unit_valid = TBL[k][22];
         rx_ovr = TBL[k][21]; tx_und = TBL[k][20]; fifo_attn = TBL[k][19:16];
         flag_clr = TBL[k][15:10];
         @(negedge clk);
         sf_valid = 0; sf_left = 0; sf_pre_b = 0; sf_pre_bad = 0; sf_cbit = 0;
         unit_valid = 0; rx_ovr = 0; tx_und = 0; flag_clr = '0;
         // covers R5 R6 R7 R8 flag behaviour
         chk($sformatf("R5/R6/R7/R8 table row %0d", k), 32'(status), 32'(TBL[k][9:0]));
         chk($sformatf("R9 table row %0d irq", k), 32'(irq), 32'(|TBL[k][9:0]));
      end
      fifo_attn = '0;

      // full block with interleaved right subframes (R1, R2, R4)
      irq_en = '0;
      do_reset();
      for (int i = 0; i < 192; i++) begin
         send_sf(1'b0, 1'b0, 1'b0, ~pat(i));
         send_sf(1'b1, i == 0, 1'b0, pat(i));
         if (i == 190) chk("R2 no early block flag", 32'(status[0]), 32'h0);
      end
      chk("R2 block flag", 32'(status[1:0]), 32'h3);
      chk_page("R1 page after block");
      chk("R4 right ignored", 32'(status[2]), 32'h0);
      // wrap to position 0
      send_sf(1'b1, 1'b0, 1'b0, ~pat(0));
      chk("R2 wrap word0", cs_page[31:0], exp_page[31:0]);

      // bad preamble left subframe stores nothing (R4, R5)
      send_sf(1'b1, 1'b0, 1'b1, ~exp_page[exp_pos]);
      chk("R4 bad ignored", cs_page[31:0], exp_page[31:0]);
      chk("R5 bad flag", 32'(status[2]), 32'h1);
      send_sf(1'b1, 1'b0, 1'b0, ~exp_page[exp_pos]);
      chk("R4 position held", cs_page[31:0], exp_page[31:0]);

      // block-start realignment mid-page (R3)
      for (int i = 0; i < 5; i++) send_sf(1'b1, 1'b0, 1'b0, 1'b1);
      send_sf(1'b1, 1'b1, 1'b0, ~exp_page[0]);
      chk("R3 restart bit0", cs_page[31:0], exp_page[31:0]);
      send_sf(1'b1, 1'b0, 1'b0, ~exp_page[1]);
      chk("R3 next at bit1", cs_page[31:0], exp_page[31:0]);

      // interrupt gating (R9, R6, R8)
      irq_en = '0;
      #1 chk("R9 all masked", 32'(irq), 32'h0);
      irq_en = 10'h008;
      #1 chk("R9 unit enable no flag", 32'(irq), 32'h0);
      unit_valid = 1;
      @(negedge clk);
      unit_valid = 0;
      chk("R6 unit flag", 32'(status[3]), 32'h1);
      chk("R9 unit irq", 32'(irq), 32'h1);
      flag_clr = 6'h08;
      @(negedge clk);
      flag_clr = '0;
      chk("R7 unit cleared", 32'(status[3]), 32'h0);
      irq_en = 10'h040;
      fifo_attn = 4'h1;
      @(negedge clk);
      chk("R8 attn irq", 32'(irq), 32'h1);
      fifo_attn = 4'h0;
      @(negedge clk);
      chk("R8 attn follows", 32'(status[6]), 32'h0);
      chk("R9 attn irq off", 32'(irq), 32'h0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule